// File: doc/BRIEF.md
# Table-Driven Complex Digital Mixer

This block shifts a wanted band of a real, digitised intermediate-frequency stream down to zero frequency. Each accepted beat carries several signed samples side by side (lane 0 is the oldest sample of the beat). Every sample is multiplied by a cosine value and by a sine value taken from two local-oscillator tables. The block returns an in-phase product stream and a quadrature product stream with the same lane layout. The oscillator frequency is set to the centre of the wanted band. The result is a complex signal, so the band is not folded.

The oscillator is not computed. Two tables each hold one period of the waveform, and the tables are walked cyclically in step with the samples. The tables are double-banked. A host writes entries into the idle bank, then issues a commit strobe with a period length. The commit swaps the banks and restarts the phase. A retune therefore never uses a half-written table.

Both streams use valid/ready. The output register holds its beat while `out_valid` is high and `out_ready` is low, and the whole two-stage pipeline stalls with it. `in_ready` is high exactly when the output register is empty or is being drained in that cycle. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. An output beat transfers when `out_valid` and `out_ready` are both high.

Top module: `cplx_lo_mixer`

## Requirements
- R1: For each lane, `out_i` is the rounded, saturated product of the input sample and the cosine entry, and `out_q` is the same for the sine entry. Samples, entries and results are two's complement signed. Lane k occupies bits [k*W +: W] of its bus.
- R2: Count accepted beats from 0, starting at the last commit. Lane k of beat n uses table entry (n*LANES + k) mod L, where L is the committed period length. Beats that are not accepted do not advance the phase.
- R3: When the pipeline is not stalled, a beat accepted in cycle c appears on the outputs in cycle c+2, with `out_valid` high. Output beats appear in input order, with no loss or duplication.
- R4: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, the output beat stays unchanged on the next cycle.
- R5: Host writes (`host_we`, with cosine and sine written together at `host_addr`) go to the idle bank. They have no effect on the outputs until a commit.
- R6: The `host_commit` strobe swaps the banks and restarts the phase at entry 0 for the next accepted beat. A beat accepted in the commit cycle still uses the old table and the old phase. After a commit, host writes land in the bank that was live before the commit.
- R7: The commit loads the period length from `host_len`. A value of 0, or a value greater than DEPTH, selects DEPTH. Periods shorter than LANES wrap correctly within a single beat.
- R8: Let p be the product and S be PSHIFT (default 2). Rounding gives floor((p + 2^(S-1)) / 2^S). The rounded value is then clamped to ±(2^(OW-1)-1), so -2^(OW-1) (-32768) never appears.
- R9: During reset and just after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high |
| in_data | input | LANES*XW (64) | Signed input samples, lane 0 in the low bits |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_i | output | LANES*OW (128) | In-phase products |
| out_q | output | LANES*OW (128) | Quadrature products |
| host_we | input | 1 | Write one entry pair into the idle bank |
| host_addr | input | $clog2(DEPTH) (10) | Entry index for the write |
| host_cos | input | TW (12) | Signed cosine entry |
| host_sin | input | TW (12) | Signed sine entry |
| host_commit | input | 1 | Swap banks, load the period length, restart the phase |
| host_len | input | $clog2(DEPTH)+1 (11) | Period length captured by the commit |

## Verification
The bench exercises the block with five kinds of input. Continuous full-scale pseudo-random samples over a 100-entry period separate per-lane phase errors from multiplier errors. Gapped input combined with irregular back-pressure shows whether the phase advances only on accepted beats and whether stalled outputs hold. A commit with a period of three, made mid-stream, checks the commit-cycle boundary and wrapping inside a single beat. A full-depth period, entered both as 0 and as an oversize length, runs past its own wrap. Alternating extreme samples against extreme table values separate saturation from rounding, including the ±0.5 rounding cases.

// File: rtl/mix_pkg.sv
package mix_pkg;

  // Round half toward +inf after an arithmetic right shift, then clamp
  // symmetrically so the most negative code never appears.
  function automatic int round_sat(input int prod, input int sh, input int ow);
    int r;
    int lim;
    if (sh > 0) r = (prod + (1 <<< (sh - 1))) >>> sh;
    else        r = prod;
    lim = (1 <<< (ow - 1)) - 1;
    if (r > lim)       r = lim;
    else if (r < -lim) r = -lim;
    return r;
  endfunction

  // Period length as committed: out-of-range requests fall back to the depth.
  function automatic int norm_len(input int len, input int depth);
    if (len <= 0 || len > depth) return depth;
    return len;
  endfunction

endpackage

// File: rtl/lo_phase_gen.sv
module lo_phase_gen #(
  parameter int LANES = 8,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      restart,
  input  logic [AW:0]               new_len,
  input  logic                      step_en,
  output logic [LANES-1:0][AW-1:0]  addr,
  output logic [AW:0]               len_q
);

  localparam int RST_STEP = LANES % DEPTH;

  logic [AW-1:0]             step_q;
  logic [LANES-1:0][AW-1:0]  init_p;
  logic [AW-1:0]             init_step;
  logic [AW:0]               acc;
  logic [LANES-1:0][AW-1:0]  nxt_p;

  // Starting pointers after a restart: 0,1,2.. wrapping at the new length,
  // and the per-beat step is the pointer one past the last lane.
  always_comb begin
    acc = '0;
    for (int k = 0; k < LANES; k++) begin
      init_p[k] = acc[AW-1:0];
      acc = ((acc + 1'b1) == new_len) ? '0 : acc + 1'b1;
    end
    init_step = acc[AW-1:0];
  end

  // Each lane pointer moves by the step; one conditional subtract suffices
  // because both pointer and step are below the length.
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [AW:0] sum;
      sum = {1'b0, addr[k]} + {1'b0, step_q};
      if (sum >= len_q) sum = sum - len_q;
      nxt_p[k] = sum[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LANES; k++) addr[k] <= AW'(k % DEPTH);
      step_q <= AW'(RST_STEP);
      len_q  <= (AW+1)'(DEPTH);
    end else if (restart) begin
      addr   <= init_p;
      step_q <= init_step;
      len_q  <= new_len;
    end else if (step_en) begin
      addr   <= nxt_p;
    end
  end

endmodule

// File: rtl/lo_table_bank.sv
module lo_table_bank #(
  parameter int LANES = 8,
  parameter int DEPTH = 1024,
  parameter int TW    = 12,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [TW-1:0]             wcos,
  input  logic [TW-1:0]             wsin,
  input  logic                      swap,
  input  logic [LANES-1:0][AW-1:0]  raddr,
  output logic [LANES-1:0][TW-1:0]  rcos,
  output logic [LANES-1:0][TW-1:0]  rsin
);

  logic [TW-1:0] cos_m [2][DEPTH];
  logic [TW-1:0] sin_m [2][DEPTH];
  logic          live;
  logic          wr_ok;

  generate
    if (DEPTH == (1 << AW)) begin : g_full
      assign wr_ok = we;
    end else begin : g_part
      assign wr_ok = we && (int'(waddr) < DEPTH);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    live <= 1'b0;
    else if (swap) live <= ~live;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      cos_m[~live][waddr] <= wcos;
      sin_m[~live][waddr] <= wsin;
    end
  end

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_rd
      assign rcos[k] = cos_m[live][raddr[k]];
      assign rsin[k] = sin_m[live][raddr[k]];
    end
  endgenerate

endmodule

// File: rtl/mix_lane.sv
module mix_lane #(
  parameter int XW = 8,
  parameter int TW = 12,
  parameter int OW = 16,
  parameter int SH = 2
) (
  input  logic signed [XW-1:0] x,
  input  logic signed [TW-1:0] c,
  input  logic signed [TW-1:0] s,
  output logic signed [OW-1:0] yi,
  output logic signed [OW-1:0] yq
);

  int pi;
  int pq;

  always_comb begin
    pi = mix_pkg::round_sat(int'(x) * int'(c), SH, OW);
    pq = mix_pkg::round_sat(int'(x) * int'(s), SH, OW);
    yi = OW'(pi);
    yq = OW'(pq);
  end

endmodule

// File: rtl/cplx_lo_mixer.sv
module cplx_lo_mixer #(
  parameter int LANES  = 8,
  parameter int XW     = 8,
  parameter int TW     = 12,
  parameter int OW     = 16,
  parameter int DEPTH  = 1024,
  parameter int PSHIFT = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*XW-1:0]   in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES*OW-1:0]   out_i,
  output logic [LANES*OW-1:0]   out_q,
  input  logic                  host_we,
  input  logic [AW-1:0]         host_addr,
  input  logic [TW-1:0]         host_cos,
  input  logic [TW-1:0]         host_sin,
  input  logic                  host_commit,
  input  logic [AW:0]           host_len
);

  logic                      adv;
  logic                      fire;
  logic [AW:0]               len_norm;
  logic [AW:0]               cur_len;
  logic [LANES-1:0][AW-1:0]  rd_addr;
  logic [LANES-1:0][TW-1:0]  tc;
  logic [LANES-1:0][TW-1:0]  ts;
  logic                      s1_v;
  logic [LANES-1:0][XW-1:0]  s1_x;
  logic [LANES-1:0][TW-1:0]  s1_c;
  logic [LANES-1:0][TW-1:0]  s1_s;
  logic [LANES-1:0][OW-1:0]  li;
  logic [LANES-1:0][OW-1:0]  lq;
  logic                      s2_v;
  logic [LANES-1:0][OW-1:0]  s2_i;
  logic [LANES-1:0][OW-1:0]  s2_q;

  assign adv      = !s2_v || out_ready;
  assign in_ready = adv;
  assign fire     = in_valid && adv;
  assign len_norm = (AW+1)'(mix_pkg::norm_len(int'(host_len), DEPTH));

  lo_phase_gen #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (host_commit),
    .new_len (len_norm),
    .step_en (fire),
    .addr    (rd_addr),
    .len_q   (cur_len)
  );

  lo_table_bank #(.LANES(LANES), .DEPTH(DEPTH), .TW(TW), .AW(AW)) u_tab (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (host_we),
    .waddr (host_addr),
    .wcos  (host_cos),
    .wsin  (host_sin),
    .swap  (host_commit),
    .raddr (rd_addr),
    .rcos  (tc),
    .rsin  (ts)
  );

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      mix_lane #(.XW(XW), .TW(TW), .OW(OW), .SH(PSHIFT)) u_mul (
        .x  (s1_x[k]),
        .c  (s1_c[k]),
        .s  (s1_s[k]),
        .yi (li[k]),
        .yq (lq[k])
      );
    end
  endgenerate

  // Stage 1: sample with its oscillator values; stage 2: rounded products.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else if (adv) begin
      s1_v <= fire;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      s1_x <= in_data;
      s1_c <= tc;
      s1_s <= ts;
    end
    if (adv && s1_v) begin
      s2_i <= li;
      s2_q <= lq;
    end
  end

  assign out_valid = s2_v;
  assign out_i     = s2_i;
  assign out_q     = s2_q;

endmodule

// File: rtl/mixer_checker.sv
module mixer_checker #(
  parameter int LANES = 8,
  parameter int OW    = 16,
  parameter int AW    = 10
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [LANES*OW-1:0]       out_i,
  input logic [LANES*OW-1:0]       out_q,
  input logic                      host_commit,
  input logic [LANES-1:0][AW-1:0]  rd_addr,
  input logic [AW:0]               cur_len
);

  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc <= '0;
    else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
  end

  function automatic logic has_min(input logic [LANES*OW-1:0] v);
    for (int k = 0; k < LANES; k++)
      if (v[k*OW +: OW] == {1'b1, {(OW-1){1'b0}}}) return 1'b1;
    return 1'b0;
  endfunction

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q))); // R4

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && out_ready && $past(out_ready) && $past(out_ready, 2))
      |-> (out_valid == $past(in_valid, 2))); // R3

  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!has_min(out_i) && !has_min(out_q))); // R8

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    host_commit |=> (rd_addr[0] == '0)); // R6

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_rng
      AST_ADDR_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_addr[k]} < cur_len)); // R2
    end
  endgenerate

endmodule

bind cplx_lo_mixer mixer_checker #(.LANES(LANES), .OW(OW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_i       (out_i),
  .out_q       (out_q),
  .host_commit (host_commit),
  .rd_addr     (rd_addr),
  .cur_len     (cur_len)
);

// File: tb/sim_cplx_lo_mixer.sv
module sim_cplx_lo_mixer;

  localparam int LANES = 8;
  localparam int XW    = 8;
  localparam int TW    = 12;
  localparam int OW    = 16;
  localparam int DEPTH = 1024;
  localparam int SH    = 2;
  localparam int AW    = 10;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic                 in_ready;
  logic [LANES*XW-1:0]  in_data;
  logic                 out_valid;
  logic                 out_ready;
  logic [LANES*OW-1:0]  out_i;
  logic [LANES*OW-1:0]  out_q;
  logic                 host_we;
  logic [AW-1:0]        host_addr;
  logic [TW-1:0]        host_cos;
  logic [TW-1:0]        host_sin;
  logic                 host_commit;
  logic [AW:0]          host_len;

  always #4 clk = ~clk;

  cplx_lo_mixer #(.LANES(LANES), .XW(XW), .TW(TW), .OW(OW), .DEPTH(DEPTH), .PSHIFT(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
    .host_we(host_we), .host_addr(host_addr), .host_cos(host_cos), .host_sin(host_sin),
    .host_commit(host_commit), .host_len(host_len)
  );

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R9";

  // Reference model state
  int liveC[DEPTH], liveS[DEPTH], shC[DEPTH], shS[DEPTH];
  int mlen  = DEPTH;
  int nbeat = 0;
  bit m1v = 0, m2v = 0;
  int m1i[LANES], m1q[LANES], m2i[LANES], m2q[LANES];
  bit fired = 0;
  logic [31:0] xs = 32'h1234_5678;
  int dmode = 0;
  int dcnt  = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R8 rule stated as floor((p + half) / 2^S), clamped to +-(2^(OW-1)-1)
  function automatic int rsat(input int p);
    int num, den, r, lim;
    den = 1 << SH;
    num = p + den / 2;
    if (num >= 0) r = num / den;
    else          r = -((-num + den - 1) / den);
    lim = (1 << (OW - 1)) - 1;
    if (r > lim)  r = lim;
    if (r < -lim) r = -lim;
    return r;
  endfunction

  function automatic int tv(input int i, input int seed, input int sel);
    return ((i * (seed * 29 + 7) + seed * 131 + sel * 977) % 4096) - 2048;
  endfunction

  function automatic logic [LANES*XW-1:0] next_data();
    logic [LANES*XW-1:0] d;
    if (dmode == 0) begin
      for (int h = 0; h < 2; h++) begin
        xs = xs ^ (xs << 13);
        xs = xs ^ (xs >> 17);
        xs = xs ^ (xs << 5);
        d[h*32 +: 32] = xs;
      end
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (dcnt % 3 == 2) d[k*XW +: XW] = (k % 2 == 0) ? 8'sd3 : -8'sd3;
        else               d[k*XW +: XW] = ((k + dcnt) % 2 == 1) ? 8'h80 : 8'h7f;
      end
      dcnt++;
    end
    return d;
  endfunction

  // Cycle model, evaluated 1 ns before each rising edge
  always @(negedge clk) begin : mon
    int x, a;
    bit adv;
    int tmp;
    #3;
    if (!rst_n) begin
      m1v = 0; m2v = 0; fired = 0;
    end else begin
      check(in_ready == (!m2v || out_ready), "R4", "in_ready", in_ready, int'(!m2v || out_ready));
      check(out_valid == m2v, "R3", "out_valid", out_valid, m2v);
      if (m2v && out_valid) begin
        for (int k = 0; k < LANES; k++) begin
          check($signed(out_i[k*OW +: OW]) == m2i[k], cur_req, $sformatf("out_i lane %0d", k),
                $signed(out_i[k*OW +: OW]), m2i[k]);
          check($signed(out_q[k*OW +: OW]) == m2q[k], cur_req, $sformatf("out_q lane %0d", k),
                $signed(out_q[k*OW +: OW]), m2q[k]);
        end
      end
      fired = in_valid && in_ready;
      adv = !m2v || out_ready;
      if (adv) begin
        m2v = m1v; m2i = m1i; m2q = m1q;
        m1v = fired;
        if (fired) begin
          for (int k = 0; k < LANES; k++) begin
            x = $signed(in_data[k*XW +: XW]);
            a = (nbeat * LANES + k) % mlen;
            m1i[k] = rsat(x * liveC[a]);
            m1q[k] = rsat(x * liveS[a]);
          end
          nbeat++;
        end
      end
      if (host_we) begin
        shC[host_addr] = $signed(host_cos);
        shS[host_addr] = $signed(host_sin);
      end
      if (host_commit) begin
        for (int i = 0; i < DEPTH; i++) begin
          tmp = liveC[i]; liveC[i] = shC[i]; shC[i] = tmp;
          tmp = liveS[i]; liveS[i] = shS[i]; shS[i] = tmp;
        end
        mlen  = (host_len == 0 || host_len > DEPTH) ? DEPTH : int'(host_len);
        nbeat = 0;
      end
    end
  end

  task automatic wr(input int addr, input int c, input int s);
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(addr); host_cos = TW'(c); host_sin = TW'(s);
  endtask

  task automatic load(input int len, input int seed);
    for (int i = 0; i < len; i++) wr(i, tv(i, seed, 0), tv(i, seed, 1));
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic commit(input int len);
    @(negedge clk);
    host_commit = 1'b1; host_len = (AW+1)'(len);
    @(negedge clk);
    host_commit = 1'b0;
  endtask

  task automatic run(input int beats, input int rmode, input int vmode);
    int sent = 0;
    int cyc  = 0;
    while (1) begin
      @(negedge clk);
      if (fired) sent++;
      if (sent >= beats) begin
        in_valid = 1'b0; out_ready = 1'b1;
        break;
      end
      if (!in_valid || fired) begin
        in_valid = (vmode == 0) || (cyc % 3 != 1);
        if (in_valid) in_data = next_data();
      end
      out_ready = (rmode == 0) || ((cyc % 4 != 0) && (cyc % 7 != 3));
      cyc++;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    host_we = 1'b0; host_addr = '0; host_cos = '0; host_sin = '0;
    host_commit = 1'b0; host_len = '0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R9", "in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);

    // R1 R2 R3: continuous random data over a 100-entry period
    load(100, 3);
    commit(100);
    cur_req = "R1 R2 R3";
    run(40, 0, 0);

    // R4: gapped input with irregular back-pressure
    cur_req = "R4 R2";
    run(40, 1, 1);

    // R5: idle-bank writes while streaming must not disturb outputs
    cur_req = "R5";
    fork
      run(60, 0, 1);
      load(3, 9);
    join

    // R6 R7: mid-stream commit to a period shorter than the lane count
    cur_req = "R6 R7";
    fork
      run(30, 0, 0);
      begin
        repeat (7) @(negedge clk);
        commit(3);
      end
    join
    drain();

    // R7: length 0 selects full depth; run past the wrap
    load(DEPTH, 5);
    commit(0);
    cur_req = "R7";
    run(140, 1, 0);
    load(DEPTH, 6);
    commit(1500);
    run(20, 0, 0);
    drain();

    // R8: extreme samples and entries, plus half-way rounding cases
    wr(0, 2047, -2048);
    wr(1, -2048, 2047);
    wr(2, 2, -2);
    wr(3, -2, 2);
    @(negedge clk);
    host_we = 1'b0;
    commit(4);
    cur_req = "R8";
    dmode = 1;
    run(12, 0, 0);
    dmode = 0;
    drain();

    #1;
    check(out_valid == 1'b0, "R3", "out_valid after drain", out_valid, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule